// File: doc/BRIEF.md
# Multi-mode CRC32 checksum unit

A streaming 32-bit cyclic redundancy engine. Message bytes come in one per clock under a valid strobe. A start flag opens a message and a last flag closes it. The remainder register divides the bit stream, modulo two, by an order-32 generator. Three generators are available: the IEEE 802 CRC32 generator, the iSCSI CRC32C generator, or a generator supplied on a configuration input. Bits enter least-significant first within each byte, and the register is kept in reflected form.

When a message closes, the unit presents a finished checksum. The checksum is the remainder put back in normal bit order, then passed through three optional steps: bit swap, byte swap and complement. For an integrity check, the message is fed together with its appended CRC. The unit then compares the raw register against the residue of the selected generator and raises a match flag when they are equal. Mode, check selection, generator, residue and transform enables are captured in the cycle that carries start, and they hold for the whole message.

Top module: `crc32_multi`

## Requirements
- R1: After reset, crc_o is 0, done_o is 0 and match_o is 0.
- R2: mode_i = 0 selects CRC32, with generator 0x04C11DB7, a preset of all ones, and data bits fed LSB first into a reflected register. The bytes of "123456789" (0x31 to 0x39) yield crc_o = 0xCBF43926.
- R3: mode_i = 1 selects CRC32C, with generator 0x1EDC6F41 under the same preset and bit order. "123456789" yields crc_o = 0xE3069283.
- R4: The checksum starts from N, which is the reflected register reversed over all 32 bits. Bit swap reverses the 8 bits inside each byte of N. Byte swap then reverses the order of the 4 bytes. Complement then inverts all bits. Modes 0 and 1 apply all three steps. Modes 2 and 3 apply each step only when swap_bits_i, swap_bytes_i or invert_i is high.
- R5: When check_i = 1, match_o is set after the last byte if and only if the raw reflected register equals the residue. The residue is 0xDEBB20E3 in mode 0, 0xB798B438 in mode 1 and residue_i in modes 2 and 3. With check_i = 0, match_o is 0.
- R6: Modes 2 and 3 use poly_i as the generator, in normal (unreflected) form. With poly_i = 0x04C11DB7 and all three enables set, "123456789" yields 0xCBF43926.
- R7: One byte is absorbed in each cycle with valid_i high. While valid_i is low, data_i and last_i have no effect.
- R8: start_i reloads the preset. A byte that arrives in the same cycle is processed from the preset. done_o pulses for one cycle, in the cycle after the byte marked last. crc_o and match_o hold their values until the next start_i, which clears both to 0 unless that same cycle also ends a message.
- R9: The configuration inputs (mode_i, check_i, poly_i, residue_i and the three enables) are sampled in the start_i cycle. Changes to them later in the message have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a message and reloads the preset |
| valid_i | input | 1 | data_i carries a message byte |
| last_i | input | 1 | The byte in this cycle is the final one |
| data_i | input | 8 | Message byte |
| mode_i | input | 2 | 0 CRC32, 1 CRC32C, 2 or 3 programmable |
| check_i | input | 1 | Integrity-check pass |
| poly_i | input | 32 | Programmable generator, normal form |
| residue_i | input | 32 | Programmable residue, reflected register form |
| swap_bits_i | input | 1 | Programmable: reverse bits within each byte |
| swap_bytes_i | input | 1 | Programmable: reverse byte order |
| invert_i | input | 1 | Programmable: complement the result |
| crc_o | output | 32 | Finished checksum |
| done_o | output | 1 | One-cycle pulse after the last byte |
| match_o | output | 1 | Residue comparison result |

## Verification
The hardest condition to reach is a change of configuration inputs in the middle of a message. Only the capture made at start may matter, and a fault there hides whenever the inputs stay still. The stimulus therefore changes mode, generator and check selection right after the first byte, and confirms that the CRC32 check value still appears. Idle cycles carrying junk data and a raised last flag are also inserted inside messages. A start pulse with no byte, and a start that coincides with a last byte, cover the clearing and preset priorities.

// File: rtl/crc32_multi_pkg.sv
package crc32_multi_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY_IEEE = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] POLY_CAST = 32'h1EDC6F41;
  localparam logic [CRC_W-1:0] RES_IEEE  = 32'hDEBB20E3;
  localparam logic [CRC_W-1:0] RES_CAST  = 32'hB798B438;

  typedef enum logic [1:0] {
    MODE_IEEE = 2'd0,
    MODE_CAST = 2'd1,
    MODE_PROG = 2'd2,
    MODE_PROG_ALT = 2'd3
  } crc_mode_e;

  typedef struct packed {
    crc_mode_e        mode;
    logic             check;
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] residue;
    logic             swap_bits;
    logic             swap_bytes;
    logic             invert;
  } crc_cfg_t;

  function automatic logic [CRC_W-1:0] rev_w(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  poly_rev_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];
  assign chain[0] = crc_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = chain[b][0] ^ data_i[b];
    assign chain[b+1] = (chain[b] >> 1) ^ ({CRC_W{fb}} & poly_rev_i);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform #(
  parameter int unsigned CRC_W = 32
) (
  input  logic [CRC_W-1:0] reg_i,
  input  logic             swap_bits_i,
  input  logic             swap_bytes_i,
  input  logic             invert_i,
  output logic [CRC_W-1:0] value_o
);
  localparam int unsigned NB = CRC_W / 8;

  logic [CRC_W-1:0] norm, bit_sw, stage1, byte_sw, stage2;

  for (genvar i = 0; i < CRC_W; i++) begin : g_norm
    assign norm[i] = reg_i[CRC_W-1-i];
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_in
      assign bit_sw[8*k+j] = norm[8*k+7-j];
    end
    assign byte_sw[8*k +: 8] = stage1[8*(NB-1-k) +: 8];
  end

  assign stage1  = swap_bits_i  ? bit_sw  : norm;
  assign stage2  = swap_bytes_i ? byte_sw : stage1;
  assign value_o = invert_i ? ~stage2 : stage2;
endmodule

// File: rtl/crc32_multi.sv
module crc32_multi
  import crc32_multi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  input  logic              check_i,
  input  logic [CRC_W-1:0]  poly_i,
  input  logic [CRC_W-1:0]  residue_i,
  input  logic              swap_bits_i,
  input  logic              swap_bytes_i,
  input  logic              invert_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              match_o
);
  crc_cfg_t cfg_live, cfg_q, cfg;
  logic [CRC_W-1:0] crc_q, crc_base, crc_next, poly_sel, res_sel, out_val;
  logic en_bits, en_bytes, en_inv, fixed_mode, end_msg;

  always_comb begin
    cfg_live.mode       = crc_mode_e'(mode_i);
    cfg_live.check      = check_i;
    cfg_live.poly       = poly_i;
    cfg_live.residue    = residue_i;
    cfg_live.swap_bits  = swap_bits_i;
    cfg_live.swap_bytes = swap_bytes_i;
    cfg_live.invert     = invert_i;
  end

  // the start cycle's byte already uses the new configuration
  assign cfg = start_i ? cfg_live : cfg_q;

  always_comb begin
    fixed_mode = 1'b0;
    poly_sel   = cfg.poly;
    res_sel    = cfg.residue;
    unique case (cfg.mode)
      MODE_IEEE: begin fixed_mode = 1'b1; poly_sel = POLY_IEEE; res_sel = RES_IEEE; end
      MODE_CAST: begin fixed_mode = 1'b1; poly_sel = POLY_CAST; res_sel = RES_CAST; end
      default: ;
    endcase
  end

  assign en_bits  = fixed_mode | cfg.swap_bits;
  assign en_bytes = fixed_mode | cfg.swap_bytes;
  assign en_inv   = fixed_mode | cfg.invert;
  assign crc_base = start_i ? '1 : crc_q;
  assign end_msg  = valid_i & last_i;

  crc_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W)) i_step (
    .crc_i      (crc_base),
    .data_i     (data_i),
    .poly_rev_i (rev_w(poly_sel)),
    .crc_o      (crc_next)
  );

  crc_out_xform #(.CRC_W(CRC_W)) i_xform (
    .reg_i        (crc_next),
    .swap_bits_i  (en_bits),
    .swap_bytes_i (en_bytes),
    .invert_i     (en_inv),
    .value_o      (out_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      crc_q   <= '1;
      crc_o   <= '0;
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      if (start_i) cfg_q <= cfg_live;
      if (valid_i) crc_q <= crc_next;
      else if (start_i) crc_q <= '1;
      done_o <= end_msg;
      if (end_msg) begin
        crc_o   <= out_val;
        match_o <= cfg.check && (crc_next == res_sel);
      end else if (start_i) begin
        crc_o   <= '0;
        match_o <= 1'b0;
      end
    end
  end

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_msg |=> done_o);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_msg |=> !done_o);
  assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!end_msg && !start_i) |=> ($stable(crc_o) && $stable(match_o)));
  assert_preset_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> (crc_q == '1));
  assert_idle_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(crc_q));
  assert_match_needs_check_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_msg && !cfg.check) |=> !match_o);
  assert_cfg_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(cfg_q));
endmodule

// File: tb/test_crc32_multi.sv
module test_crc32_multi;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, valid = 0, last = 0, check = 0, sbit = 0, sbyte = 0, inv = 0;
  logic [7:0]  data = 0;
  logic [1:0]  mode = 0;
  logic [31:0] poly = 0, resid = 0;
  logic [31:0] crc_o;
  logic done_o, match_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference state (normal-form register)
  logic [31:0] m_n = '1, exp_crc = 0;
  logic exp_done = 0, exp_match = 0;
  logic [1:0] m_mode = 0; logic m_check = 0, m_sb = 0, m_sy = 0, m_iv = 0;
  logic [31:0] m_poly = 0, m_res = 0;

  always #10 clk = ~clk;

  crc32_multi i_crc32_multi (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .last_i(last),
    .data_i(data), .mode_i(mode), .check_i(check), .poly_i(poly), .residue_i(resid),
    .swap_bits_i(sbit), .swap_bytes_i(sbyte), .invert_i(inv),
    .crc_o(crc_o), .done_o(done_o), .match_o(match_o));

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] xform(input logic [31:0] n, input logic b, input logic y, input logic i);
    logic [31:0] v = n;
    if (b) for (int k = 0; k < 4; k++) v[8*k +: 8] = {<<{n[8*k +: 8]}};
    if (y) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
    if (i) v = ~v;
    return v;
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      logic [31:0] g, r;
      logic fix;
      if (start) begin
        m_mode = mode; m_check = check; m_poly = poly; m_res = resid;
        m_sb = sbit; m_sy = sbyte; m_iv = inv;
        m_n = '1;
      end
      fix = (m_mode < 2);
      g = (m_mode == 0) ? 32'h04C11DB7 : (m_mode == 1) ? 32'h1EDC6F41 : m_poly;
      r = (m_mode == 0) ? 32'hDEBB20E3 : (m_mode == 1) ? 32'hB798B438 : m_res;
      exp_done = 0;
      if (valid) begin
        for (int i = 0; i < 8; i++) begin
          logic fb;
          fb = m_n[31] ^ data[i];
          m_n = {m_n[30:0], 1'b0} ^ (fb ? g : 32'h0);
        end
        if (last) begin
          exp_done = 1;
          exp_crc = xform(m_n, fix | m_sb, fix | m_sy, fix | m_iv);
          exp_match = m_check && (rev(m_n) == r);
        end
      end
      if (start && !(valid && last)) begin exp_crc = 0; exp_match = 0; end
    end
  end

  always @(negedge clk) begin
    check_eq({cur_req, " crc_o"}, crc_o, exp_crc);
    check_eq({cur_req, " done_o"}, {31'b0, done_o}, {31'b0, exp_done});
    check_eq({cur_req, " match_o"}, {31'b0, match_o}, {31'b0, exp_match});
  end

  task automatic send(input logic [7:0] msg[$], input bit gaps, input bit scramble);
    for (int i = 0; i < msg.size(); i++) begin
      if (gaps && i > 0 && (i % 2 == 1)) begin
        @(negedge clk);
        start = 0; valid = 0; last = 1; data = 8'($urandom);
      end
      @(negedge clk);
      start = (i == 0); valid = 1; last = (i == msg.size() - 1); data = msg[i];
      if (scramble && i == 1) begin
        mode = 2'd1; check = ~check; poly = 32'h12345678; sbit = ~sbit; inv = ~inv;
      end
    end
    @(negedge clk);
    start = 0; valid = 0; last = 0; data = 0;
  endtask

  task automatic cfg_set(input logic [1:0] m, input logic c, input logic [31:0] p,
                         input logic [31:0] rr, input logic b, input logic y, input logic i);
    mode = m; check = c; poly = p; resid = rr; sbit = b; sbyte = y; inv = i;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s[$];
    logic [7:0] t[$];
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check_eq("R1 reset crc_o", crc_o, 32'h0);
    check_eq("R1 reset done_o", {31'b0, done_o}, 32'h0);
    check_eq("R1 reset match_o", {31'b0, match_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2"; cfg_set(0, 0, 0, 0, 0, 0, 0);
    send(s, 0, 0);
    check_eq("R2 crc32 check string", crc_o, 32'hCBF43926);

    cur_req = "R3"; cfg_set(1, 0, 0, 0, 0, 0, 0);
    send(s, 0, 0);
    check_eq("R3 crc32c check string", crc_o, 32'hE3069283);

    cur_req = "R5"; cfg_set(0, 1, 0, 0, 0, 0, 0);
    t = s; t.push_back(8'h26); t.push_back(8'h39); t.push_back(8'hF4); t.push_back(8'hCB);
    send(t, 0, 0);
    check_eq("R5 crc32 residue match", {31'b0, match_o}, 32'h1);
    t[9] = 8'h27;
    send(t, 0, 0);
    check_eq("R5 corrupted no match", {31'b0, match_o}, 32'h0);
    cfg_set(1, 1, 0, 0, 0, 0, 0);
    t = s; t.push_back(8'h83); t.push_back(8'h92); t.push_back(8'h06); t.push_back(8'hE3);
    send(t, 0, 0);
    check_eq("R5 crc32c residue match", {31'b0, match_o}, 32'h1);
    cfg_set(0, 0, 0, 0, 0, 0, 0);
    t = s; t.push_back(8'h26); t.push_back(8'h39); t.push_back(8'hF4); t.push_back(8'hCB);
    send(t, 0, 0);
    check_eq("R5 no check selected", {31'b0, match_o}, 32'h0);

    cur_req = "R6"; cfg_set(2, 0, 32'h04C11DB7, 0, 1, 1, 1);
    send(s, 0, 0);
    check_eq("R6 programmable crc32", crc_o, 32'hCBF43926);
    cfg_set(3, 1, 32'h1EDC6F41, 32'hB798B438, 1, 1, 1);
    t = s; t.push_back(8'h83); t.push_back(8'h92); t.push_back(8'h06); t.push_back(8'hE3);
    send(t, 0, 0);
    check_eq("R6 programmable residue", {31'b0, match_o}, 32'h1);

    cur_req = "R4"; cfg_set(2, 0, 32'h04C11DB7, 0, 0, 0, 0);
    send(s, 0, 0);
    check_eq("R4 no transform", crc_o, rev(32'h340BC6D9));
    cfg_set(2, 0, 32'h04C11DB7, 0, 0, 0, 1);
    send(s, 0, 0);
    check_eq("R4 invert only", crc_o, ~rev(32'h340BC6D9));
    cfg_set(2, 0, 32'h04C11DB7, 0, 1, 0, 0);
    send(s, 0, 0);
    check_eq("R4 bit swap only", crc_o, xform(rev(32'h340BC6D9), 1, 0, 0));
    cfg_set(2, 0, 32'h04C11DB7, 0, 0, 1, 0);
    send(s, 0, 0);
    check_eq("R4 byte swap only", crc_o, xform(rev(32'h340BC6D9), 0, 1, 0));

    cur_req = "R7"; cfg_set(0, 0, 0, 0, 0, 0, 0);
    send(s, 1, 0);
    check_eq("R7 idle gaps ignored", crc_o, 32'hCBF43926);

    cur_req = "R8";
    repeat (3) @(negedge clk);
    check_eq("R8 held after done", crc_o, 32'hCBF43926);
    start = 1; @(negedge clk); start = 0;
    check_eq("R8 start clears crc_o", crc_o, 32'h0);
    t = '{8'h5A};
    send(t, 0, 0);
    t = '{8'h31};
    send(s, 0, 0);

    cur_req = "R9"; cfg_set(0, 0, 0, 0, 1, 0, 0);
    send(s, 0, 1);
    check_eq("R9 config latched at start", crc_o, 32'hCBF43926);

    cur_req = "R2";
    for (int k = 0; k < 24; k++) begin
      t = {};
      for (int j = 0; j < 1 + (k % 13); j++) t.push_back(8'($urandom));
      cfg_set(2'(k % 4), 1'(k % 2), $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
      send(t, k % 3 == 0, 0);
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule